// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is an I2C target (slave) that gives a host controller read and write access to a small bank of 8-bit configuration registers. All access goes through an internal register index held in the block. A write transaction first carries an index byte and then zero or more data bytes. A read transaction returns the register the index selects. One flag in the index byte chooses whether the index steps forward after each data byte. The index is kept between transactions, so a read can follow an earlier write of the index, either after a repeated START or in a new transaction.

The block samples SCL and SDA from the pads through a synchronizer running on the system clock and detects START, repeated START and STOP. It answers to a 7-bit device identity whose upper five bits are fixed by a parameter and whose lowest two bits come from board strap inputs. SDA is never driven high. The block only asserts an open-drain pull-down enable, and the pad logic outside the block turns that into a low on the wire. The register contents are brought out in parallel, where the functions they configure can read them.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset the pull-down enable `sda_oe` is 0, every register reads 0x00, the register index is 0 and the step flag is 0.
- R2: The first byte after a START is accepted only if its upper seven bits equal {1,0,0,1,0,`strap_a1`,`strap_a0`}. Bit 0 of that byte selects read (1) or write (0). An accepted address is acknowledged by pulling SDA low during the ninth SCL pulse. A mismatching address gets no acknowledge, and the block ignores the bus until the next START or STOP, with all registers unchanged.
- R3: In a write, the first byte after the address is the index byte. Bit 7 is the step flag and the low log2(N_REGS) bits (bits 2:0 by default) are the register index. The remaining bits are ignored. The byte is acknowledged.
- R4: Each further byte of a write is stored into the register the index selects, appears on `regs_o` (register k at bits 8k+7:8k), and is acknowledged.
- R5: With the step flag at 1, the index advances by one after each data byte written or sent, wrapping from N_REGS-1 to 0.
- R6: With the step flag at 0, the index stays put: repeated data bytes overwrite the same register, and repeated read bytes return the same register.
- R7: In a read, the selected register is sent MSB first, starting in the SCL low phase that follows the address acknowledge. When the host acknowledges a byte, the next byte follows.
- R8: When the host does not acknowledge a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R9: The index and step flag keep their values from one transaction to the next. A read that is the first access after reset starts at register 0.
- R10: A repeated START at any point restarts the address phase without a STOP, so an index write followed by a repeated START and a read address returns the newly selected register.
- R11: `sda_oe` changes only while SCL is low.
- R12: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP, and a STOP in the middle of a byte abandons that byte without writing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| strap_a1 | input | 1 | Strapped device identity bit 1 |
| strap_a0 | input | 1 | Strapped device identity bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | N_REGS*8 | Parallel view of the register bank |

## Verification
The hardest situation to reach from the pins is the quiet state after a host NACK in a burst read. Reaching it takes several acknowledged bytes with the step flag set, a wrap of the index, and then a refused byte. Only then can the bench see whether the block keeps shifting data onto the wire. The bench gets there by first writing a burst that starts two registers below the top of the bank. It then writes the index again, issues a repeated START and reads three bytes, refusing the last one. After that it clocks a further nine bits and counts any low level it sees on SDA.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    S_IDLE,  // bus free or not yet addressed
    S_RX,    // shifting in a byte
    S_ACK,   // holding SDA low for an acknowledge
    S_TX,    // shifting out a register byte
    S_MACK,  // waiting for the host acknowledge bit
    S_SKIP   // ignoring the bus until START or STOP
  } bus_state_e;

  typedef enum logic [1:0] {
    P_ADDR,
    P_INDEX,
    P_DATA
  } rx_phase_e;

  // Identity compare: fixed high bits plus two strap bits.
  function automatic logic id_match(input logic [6:0] id,
                                    input logic [4:0] fixed,
                                    input logic       s1,
                                    input logic       s0);
    return id == {fixed, s1, s0};
  endfunction

  // Index step: unchanged when the flag is clear, else +1 modulo the bank.
  function automatic logic [7:0] next_index(input logic [7:0] idx,
                                            input logic       step,
                                            input logic [7:0] mask);
    return step ? ((idx + 8'd1) & mask) : idx;
  endfunction

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s && !scl_d;
  assign scl_fall = !scl_s && scl_d;
  // R12: conditions need SCL high on both samples around the SDA edge
  assign start_ev = scl_s && scl_d && sda_d && !sda_s;
  assign stop_ev  = scl_s && scl_d && !sda_d && sda_s;

endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank #(
  parameter int N_REGS = 8,
  localparam int PW    = $clog2(N_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [PW-1:0]       waddr,
  input  logic [7:0]          wdata,
  input  logic [PW-1:0]       raddr,
  output logic [7:0]          rdata,
  output logic [N_REGS*8-1:0] regs_flat
);

  logic [7:0] mem [N_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  for (genvar g = 0; g < N_REGS; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = mem[g];
  end

  // R4: a write strobe lands in the addressed register one cycle later
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int         N_REGS      = 8,
  parameter logic [4:0] ID_FIXED    = 5'b10010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                strap_a1,
  input  logic                strap_a0,
  output logic                sda_oe,
  output logic [N_REGS*8-1:0] regs_o
);
  import cfg_i2c_pkg::*;

  localparam int         PW       = $clog2(N_REGS);
  localparam logic [7:0] IDX_MASK = 8'(N_REGS - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bus_state_e state;
  rx_phase_e  phase;
  logic [2:0] cnt;
  logic       rx_full;
  logic [7:0] shreg;
  logic [PW-1:0] idx;
  logic       step;
  logic       rd_mode;
  logic       mack;
  logic [7:0] rdata;

  // Named events for assertions and readability
  logic          byte_done, addr_hit, wr_en, load_tx;
  logic [PW-1:0] idx_nxt;

  assign byte_done = (state == S_RX) && rx_full && scl_fall;
  assign addr_hit  = id_match(shreg[7:1], ID_FIXED, strap_a1, strap_a0);
  assign wr_en     = byte_done && (phase == P_DATA);
  assign load_tx   = scl_fall && (((state == S_ACK) && rd_mode) ||
                                  ((state == S_MACK) && mack));
  assign idx_nxt   = PW'(next_index(8'(idx), step, IDX_MASK));

  cfg_i2c_regbank #(.N_REGS(N_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(idx), .wdata(shreg),
    .raddr(idx), .rdata(rdata), .regs_flat(regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= P_ADDR;
      cnt     <= '0;
      rx_full <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      step    <= 1'b0;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      state   <= S_RX;
      phase   <= P_ADDR;
      cnt     <= '0;
      rx_full <= 1'b0;
      rd_mode <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      state   <= S_IDLE;
      rx_full <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        S_RX: begin
          if (scl_rise && !rx_full) begin
            shreg <= {shreg[6:0], sda_s};
            if (cnt == 3'd7) rx_full <= 1'b1;
            else             cnt     <= cnt + 3'd1;
          end
          if (byte_done) begin
            rx_full <= 1'b0;
            cnt     <= '0;
            unique case (phase)
              P_ADDR: begin
                if (addr_hit) begin
                  rd_mode <= shreg[0];
                  phase   <= P_INDEX;
                  sda_oe  <= 1'b1;
                  state   <= S_ACK;
                end else begin
                  state   <= S_SKIP;
                end
              end
              P_INDEX: begin
                idx    <= shreg[PW-1:0];
                step   <= shreg[7];
                phase  <= P_DATA;
                sda_oe <= 1'b1;
                state  <= S_ACK;
              end
              default: begin
                idx    <= idx_nxt;
                sda_oe <= 1'b1;
                state  <= S_ACK;
              end
            endcase
          end
        end
        S_ACK, S_MACK: begin
          if (state == S_MACK && scl_rise) mack <= !sda_s;
          if (load_tx) begin
            shreg  <= rdata;
            sda_oe <= !rdata[7];
            idx    <= idx_nxt;
            cnt    <= '0;
            state  <= S_TX;
          end else if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= (state == S_ACK) ? S_RX : S_SKIP;
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              mack   <= 1'b0;
              state  <= S_MACK;
            end else begin
              cnt    <= cnt + 3'd1;
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= !shreg[6];
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R11: the pull-down only moves while synchronized SCL is low
  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R12: a STOP frees the line and returns to idle
  a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_oe && state == S_IDLE));

  // R8: while ignoring the bus the line is never pulled
  a_r8_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |-> !sda_oe);

  // R5: a stored byte with the step flag set moves the index by one
  a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && step) |=> idx == PW'($past(idx) + 1'b1));

  // R6: a stored byte with the step flag clear leaves the index alone
  a_r6_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !step) |=> $stable(idx));

endmodule

// File: tb/sim_cfg_i2c_target.sv
`timescale 1ns/1ps
module sim_cfg_i2c_target;
  localparam int NREG = 8;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic a1 = 1'b0, a0 = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire  sda_line = !(m_low || sda_oe);

  int n_cmp = 0, n_bad = 0, r11_viol = 0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;

  cfg_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_a1(a1), .strap_a0(a0), .sda_oe(sda_oe), .regs_o(regs_o)
  );

  // R11 monitor: pull-down must never move with SCL high
  always @(sda_oe) if (rst_n && scl) r11_viol++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] bank_image();
    logic [NREG*8-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    if (!scl) begin m_low = 1'b0; wq(); scl = 1'b1; wq(); end
    m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq(); wq();
  endtask

  task automatic bit_slot(input logic b, output logic seen);
    m_low = !b; wq(); scl = 1'b1; wq(); seen = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], s);
    bit_slot(1'b1, s);
    ack = !s;
  endtask

  task automatic rx_byte(output logic [7:0] b, input logic give_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_slot(1'b1, s); b[i] = s; end
    bit_slot(!give_ack, s);
  endtask

  function automatic logic [7:0] id_byte(input logic rw);
    return {5'b10010, a1, a0, rw};
  endfunction

  // Table: {index, value}; written with step flag 0 then read back
  localparam logic [15:0] VEC [6] = '{16'h005A, 16'h03C3, 16'h0781,
                                      16'h01FF, 16'h043C, 16'h02A5};

  initial begin
    logic ack;
    logic [7:0] d;
    int zeros;
    for (int k = 0; k < NREG; k++) model[k] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 sda_oe after reset", 64'(sda_oe), 64'd0);
    check("R1 bank after reset", 64'(regs_o), 64'(bank_image()));

    // R9 first access is a read from index 0
    bus_start(); tx_byte(id_byte(1'b1), ack);
    check("R9 read address acked", 64'(ack), 64'd1);
    rx_byte(d, 1'b0);
    check("R9 first read from index 0", 64'(d), 64'(model[0]));
    bus_stop();

    // Table walk: R3 R4 R7 R10
    for (int v = 0; v < 6; v++) begin
      logic [7:0] ix, val;
      ix = VEC[v][15:8]; val = VEC[v][7:0];
      bus_start(); tx_byte(id_byte(1'b0), ack);
      check("R2 write address acked", 64'(ack), 64'd1);
      tx_byte(ix, ack);
      check("R3 index byte acked", 64'(ack), 64'd1);
      tx_byte(val, ack);
      check("R4 data byte acked", 64'(ack), 64'd1);
      model[ix[2:0]] = val;
      check("R4 bank after write", 64'(regs_o), 64'(bank_image()));
      bus_stop();
      bus_start(); tx_byte(id_byte(1'b0), ack); tx_byte(ix, ack);
      bus_start(); tx_byte(id_byte(1'b1), ack);
      check("R10 read after repeated START acked", 64'(ack), 64'd1);
      rx_byte(d, 1'b0);
      check("R7 read back value", 64'(d), 64'(val));
      bus_stop();
    end

    // R5 burst write with wrap: 6,7,0
    bus_start(); tx_byte(id_byte(1'b0), ack); tx_byte(8'h86, ack);
    tx_byte(8'h11, ack); tx_byte(8'h22, ack); tx_byte(8'h33, ack);
    bus_stop();
    model[6] = 8'h11; model[7] = 8'h22; model[0] = 8'h33;
    check("R5 burst write with wrap", 64'(regs_o), 64'(bank_image()));

    // R9 index retained (now 1) across transactions
    bus_start(); tx_byte(id_byte(1'b1), ack); rx_byte(d, 1'b0); bus_stop();
    check("R9 index kept between transactions", 64'(d), 64'(model[1]));

    // R5/R7 burst read with wrap, then R8 quiet after NACK
    bus_start(); tx_byte(id_byte(1'b0), ack); tx_byte(8'h86, ack);
    bus_start(); tx_byte(id_byte(1'b1), ack);
    rx_byte(d, 1'b1); check("R7 burst byte 0", 64'(d), 64'(model[6]));
    rx_byte(d, 1'b1); check("R5 burst byte 1", 64'(d), 64'(model[7]));
    rx_byte(d, 1'b0); check("R5 burst wrap byte", 64'(d), 64'(model[0]));
    zeros = 0;
    for (int i = 0; i < 9; i++) begin logic s; bit_slot(1'b1, s); if (!s) zeros++; end
    check("R8 line quiet after NACK", 64'(zeros), 64'd0);
    bus_stop();

    // R6 step flag clear: overwrite and repeat
    bus_start(); tx_byte(id_byte(1'b0), ack); tx_byte(8'h05, ack);
    tx_byte(8'h44, ack); tx_byte(8'h55, ack);
    model[5] = 8'h55;
    check("R6 same register overwritten", 64'(regs_o), 64'(bank_image()));
    bus_start(); tx_byte(id_byte(1'b1), ack);
    rx_byte(d, 1'b1); check("R6 repeat read 0", 64'(d), 64'h55);
    rx_byte(d, 1'b0); check("R6 repeat read 1", 64'(d), 64'h55);
    bus_stop();

    // R3 upper index bits ignored: 0x7B -> flag 0, index 3
    bus_start(); tx_byte(id_byte(1'b0), ack); tx_byte(8'h7B, ack);
    tx_byte(8'h66, ack); bus_stop();
    model[3] = 8'h66;
    check("R3 upper index bits ignored", 64'(regs_o), 64'(bank_image()));

    // R2 wrong identity: no ack, bus ignored
    bus_start(); tx_byte({5'b10010, a1, !a0, 1'b0}, ack);
    check("R2 foreign address not acked", 64'(ack), 64'd0);
    tx_byte(8'h00, ack);
    check("R2 ignored byte not acked", 64'(ack), 64'd0);
    tx_byte(8'hEE, ack); bus_stop();
    check("R2 bank untouched", 64'(regs_o), 64'(bank_image()));

    // R12 STOP inside a data byte abandons it
    bus_start(); tx_byte(id_byte(1'b0), ack); tx_byte(8'h02, ack);
    for (int i = 0; i < 4; i++) begin logic s; bit_slot(1'b0, s); end
    bus_stop();
    check("R12 partial byte not stored", 64'(regs_o), 64'(bank_image()));
    bus_start(); tx_byte(id_byte(1'b0), ack); tx_byte(8'h02, ack);
    tx_byte(8'h77, ack); bus_stop();
    model[2] = 8'h77;
    check("R12 recovers after STOP", 64'(regs_o), 64'(bank_image()));

    // R2 strap inputs select identity
    a1 = 1'b1; a0 = 1'b0;
    bus_start(); tx_byte(id_byte(1'b0), ack); bus_stop();
    check("R2 new strap identity acked", 64'(ack), 64'd1);
    bus_start(); tx_byte(8'h90, ack); bus_stop();
    check("R2 old identity refused", 64'(ack), 64'd0);

    check("R11 no SDA move while SCL high", 64'(r11_viol), 64'd0);
    check("R1 sda released at end", 64'(sda_oe), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all R) actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule